// File: doc/BRIEF.md
# Signature Store Decoder

This block watches a data-memory bus from the side and picks out the stores that land on one configurable signature address. Each such store is read either as the head of a typed report message or as a continuation word of one that is already open. The decoded reports come out as records on a valid/ready port: status words, test verdicts, a full register dump, and identifier/value pairs for control registers. The block never answers the bus and never stalls it.

The low byte of a head store chooses the message type. That type also decides how many further signature stores belong to the message. A built-in status checker can be armed in two ways. In compare-next mode it judges the next status report against an expected value. In wait mode it drops status reports until one matches a target, then signals completion. After reset the checker is already armed in compare-next mode and expects the initialised status. Records pass through a small queue. If the queue is full when a record arrives, the record is lost and a sticky overflow flag records the loss.

Top module: `sigdec_top`

## Requirements
- R1: A bus beat counts as a signature store only when busReq and busWe are both high and busAddr equals sigAddr. Reads and stores to any other address produce no record and no flag.
- R2: Type byte busWdata[7:0] = 0 (status) or 1 (verdict) when no message is open gives one record. The record has recKind 0 or 1, recTag 0 and recData = busWdata >> 8. It is visible at the output one clock edge after the store.
- R3: Type byte 2 opens a register dump and produces no record itself. Each of the next NREG signature stores gives a record with recKind 2, recTag equal to the index counting from 0, and recData equal to the full word, whatever its low byte. Other bus traffic in between is skipped.
- R4: Type byte 3 produces no record. The next signature store gives a record with recKind 3, recTag = (first word >> 8) and recData = the full second word.
- R5: A signature store with a type byte above 3 while no message is open raises fmtErr for one cycle and produces no record.
- R6: After reset the checker is armed in compare-next mode with target 0 (initialised). The first status report raises waitDone if its payload is 0, and mismatchErr otherwise. That report is still output, and the checker then disarms.
- R7: chkArm with chkMode = 1 arms compare-next mode with chkTarget. Only the next status report is judged, as in R6. Later status reports raise no flag.
- R8: chkArm with chkMode = 2 arms wait mode. Status reports whose payload differs from chkTarget are discarded with no record and no flag. The first match is output, raises waitDone for one cycle, and disarms the checker.
- R9: Records leave in arrival order. While recReady is low, recValid and the record fields hold steady. Up to DEPTH records are queued.
- R10: A record that arrives while DEPTH records are already queued is dropped, and ovfFlag rises and stays high until reset.
- R11: chkArm with chkMode = 0 disarms the checker, so status reports raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Bus beat present |
| busWe | input | 1 | Beat is a store |
| busAddr | input | AW | Beat address |
| busWdata | input | DW | Store data |
| sigAddr | input | AW | Signature address to match |
| chkArm | input | 1 | Load chkMode and chkTarget into the checker |
| chkMode | input | 2 | 0 off, 1 compare-next, 2 wait-for-match |
| chkTarget | input | DW-8 | Expected status payload |
| recValid | output | 1 | Record available |
| recReady | input | 1 | Consumer takes the record |
| recKind | output | 2 | 0 status, 1 verdict, 2 dump, 3 control register |
| recTag | output | DW | Dump index or register identifier, otherwise 0 |
| recData | output | DW | Record payload |
| fmtErr | output | 1 | Unknown type byte pulse |
| mismatchErr | output | 1 | Compare-next failure pulse |
| waitDone | output | 1 | Checker matched pulse |
| ovfFlag | output | 1 | Sticky record-loss flag |

## Verification
The bench builds the block with DEPTH = 4 and the other parameters at their defaults. The shallow queue lets five back-to-back verdicts trigger the overflow, and the drop of the fifth record can then be seen at the output. With the full dump length of 32 the bench reaches the last index and the return to head decoding. It does this by draining each dump record as it arrives and mixing foreign stores, and a continuation word whose low byte would otherwise be a format error, into the dump.

// File: rtl/sigdec_pkg.sv
package sigdec_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    K_STATUS = 2'd0,
    K_RESULT = 2'd1,
    K_DUMP   = 2'd2,
    K_CSR    = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CM_OFF  = 2'd0,
    CM_NEXT = 2'd1,
    CM_WAIT = 2'd2
  } chkmode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DUMP = 2'd1,
    ST_CSR  = 2'd2
  } state_e;

  // strobes from control to datapath for the current signature store
  typedef struct packed {
    logic              push;
    kind_e             kind;
    logic              latchId;
    logic              fullWord;
    logic [IDX_W-1:0]  idx;
  } strobe_t;
endpackage

// File: rtl/sigdec_ctrl.sv
module sigdec_ctrl
  import sigdec_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          store,
  input  logic [DW-1:0] wdata,
  input  logic          chkArm,
  input  logic [1:0]    chkMode,
  input  logic [DW-9:0] chkTarget,
  input  logic          fifoFull,
  output strobe_t       strb,
  output logic          fmtErr,
  output logic          mismatchErr,
  output logic          waitDone,
  output logic          ovfFlag
);
  localparam int PW = DW - 8;

  state_e         state, stNext;
  logic [IDX_W-1:0] cnt, cntNext;
  logic           armed;
  chkmode_e       modeQ;
  logic [PW-1:0]  targetQ;
  logic           fmtNext, misNext, doneNext, disarm;

  logic [7:0]     typeByte;
  logic [PW-1:0]  payload;
  logic           isMatch;

  assign typeByte = wdata[7:0];
  assign payload  = wdata[DW-1:8];
  assign isMatch  = (payload == targetQ);

  always_comb begin
    stNext   = state;
    cntNext  = cnt;
    strb     = '0;
    fmtNext  = 1'b0;
    misNext  = 1'b0;
    doneNext = 1'b0;
    disarm   = 1'b0;
    if (store) begin
      unique case (state)
        ST_IDLE: begin
          unique case (typeByte)
            8'd0: begin
              strb.kind = K_STATUS;
              strb.push = 1'b1;
              if (armed && modeQ == CM_NEXT) begin
                disarm   = 1'b1;
                doneNext = isMatch;
                misNext  = !isMatch;
              end else if (armed && modeQ == CM_WAIT) begin
                strb.push = isMatch;
                doneNext  = isMatch;
                disarm    = isMatch;
              end
            end
            8'd1: begin
              strb.kind = K_RESULT;
              strb.push = 1'b1;
            end
            8'd2: begin
              stNext  = ST_DUMP;
              cntNext = '0;
            end
            8'd3: begin
              strb.latchId = 1'b1;
              stNext       = ST_CSR;
            end
            default: fmtNext = 1'b1;
          endcase
        end
        ST_DUMP: begin
          strb.push     = 1'b1;
          strb.kind     = K_DUMP;
          strb.fullWord = 1'b1;
          strb.idx      = cnt;
          cntNext       = cnt + 1'b1;
          if (cnt == IDX_W'(NREG - 1)) begin
            stNext  = ST_IDLE;
            cntNext = '0;
          end
        end
        ST_CSR: begin
          strb.push     = 1'b1;
          strb.kind     = K_CSR;
          strb.fullWord = 1'b1;
          stNext        = ST_IDLE;
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      armed       <= 1'b1;
      modeQ       <= CM_NEXT;
      targetQ     <= '0;
      fmtErr      <= 1'b0;
      mismatchErr <= 1'b0;
      waitDone    <= 1'b0;
      ovfFlag     <= 1'b0;
    end else begin
      state       <= stNext;
      cnt         <= cntNext;
      fmtErr      <= fmtNext;
      mismatchErr <= misNext;
      waitDone    <= doneNext;
      if (strb.push && fifoFull) ovfFlag <= 1'b1;
      if (chkArm) begin
        modeQ   <= chkmode_e'(chkMode);
        targetQ <= chkTarget;
        armed   <= (chkMode == CM_NEXT) || (chkMode == CM_WAIT);
      end else if (disarm) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sigdec_dpath.sv
module sigdec_dpath
  import sigdec_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [DW-1:0] wdata,
  input  logic          recReady,
  output logic          recValid,
  output logic [1:0]    recKind,
  output logic [DW-1:0] recTag,
  output logic [DW-1:0] recData,
  output logic          fifoFull
);
  localparam int PW   = DW - 8;
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]   csrIdQ;
  logic [1:0]      memKind [DEPTH];
  logic [DW-1:0]   memTag  [DEPTH];
  logic [DW-1:0]   memData [DEPTH];
  logic [PTRW-1:0] wPtr, rPtr;
  logic [PTRW:0]   level;
  logic [DW-1:0]   newTag, newData;
  logic            doPush, doPop;

  always_comb begin
    unique case (strb.kind)
      K_DUMP:  newTag = DW'(strb.idx);
      K_CSR:   newTag = DW'(csrIdQ);
      default: newTag = '0;
    endcase
  end
  assign newData  = strb.fullWord ? wdata : DW'(wdata[DW-1:8]);

  assign fifoFull = (level == (PTRW+1)'(DEPTH));
  assign recValid = (level != '0);
  assign doPush   = strb.push && !fifoFull;
  assign doPop    = recValid && recReady;
  assign recKind  = memKind[rPtr];
  assign recTag   = memTag[rPtr];
  assign recData  = memData[rPtr];

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csrIdQ <= '0;
      wPtr   <= '0;
      rPtr   <= '0;
      level  <= '0;
    end else begin
      if (strb.latchId) csrIdQ <= wdata[DW-1:8];
      if (doPush) wPtr <= bump(wPtr);
      if (doPop)  rPtr <= bump(rPtr);
      level <= level + (doPush ? 1'b1 : 1'b0) - (doPop ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) begin
      memKind[wPtr] <= strb.kind;
      memTag[wPtr]  <= newTag;
      memData[wPtr] <= newData;
    end
  end
endmodule

// File: rtl/sigdec_top.sv
module sigdec_top
  import sigdec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int NREG  = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReq,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic [AW-1:0] sigAddr,
  input  logic          chkArm,
  input  logic [1:0]    chkMode,
  input  logic [DW-9:0] chkTarget,
  output logic          recValid,
  input  logic          recReady,
  output logic [1:0]    recKind,
  output logic [DW-1:0] recTag,
  output logic [DW-1:0] recData,
  output logic          fmtErr,
  output logic          mismatchErr,
  output logic          waitDone,
  output logic          ovfFlag
);
  strobe_t strb;
  logic    store;
  logic    fifoFull;

  assign store = busReq && busWe && (busAddr == sigAddr);

  sigdec_ctrl #(.DW(DW), .NREG(NREG)) u_ctrl (
    .clk(clk), .rstN(rstN), .store(store), .wdata(busWdata),
    .chkArm(chkArm), .chkMode(chkMode), .chkTarget(chkTarget),
    .fifoFull(fifoFull), .strb(strb), .fmtErr(fmtErr),
    .mismatchErr(mismatchErr), .waitDone(waitDone), .ovfFlag(ovfFlag)
  );

  sigdec_dpath #(.DW(DW), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .recReady(recReady), .recValid(recValid), .recKind(recKind),
    .recTag(recTag), .recData(recData), .fifoFull(fifoFull)
  );
endmodule

// File: rtl/sigdec_chk.sv
module sigdec_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          busReq,
  input logic          busWe,
  input logic [AW-1:0] busAddr,
  input logic [AW-1:0] sigAddr,
  input logic          recValid,
  input logic          recReady,
  input logic [1:0]    recKind,
  input logic [DW-1:0] recTag,
  input logic [DW-1:0] recData,
  input logic          fmtErr,
  input logic          mismatchErr,
  input logic          waitDone,
  input logic          ovfFlag
);
  logic hit;
  assign hit = busReq && busWe && (busAddr == sigAddr);

  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> !fmtErr && !mismatchErr && !waitDone); // R1
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    !recValid && !hit |=> !recValid); // R1
  AST_HOLD_REC: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recKind) && $stable(recTag) && $stable(recData)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag); // R10
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(mismatchErr && waitDone)); // R6
  AST_FMT_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> !mismatchErr && !waitDone); // R5
endmodule

bind sigdec_top sigdec_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
  .sigAddr(sigAddr), .recValid(recValid), .recReady(recReady), .recKind(recKind),
  .recTag(recTag), .recData(recData), .fmtErr(fmtErr), .mismatchErr(mismatchErr),
  .waitDone(waitDone), .ovfFlag(ovfFlag)
);

// File: tb/sigdec_top_tb.sv
module sigdec_top_tb;
  localparam int AW = 32, DW = 32, DEPTH = 4, NREG = 32;
  localparam logic [AW-1:0] SIG = 32'h0000_8000;

  logic clk = 1'b0, rstN = 1'b0;
  logic busReq = 0, busWe = 0, chkArm = 0, recReady = 0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [1:0] chkMode = '0;
  logic [DW-9:0] chkTarget = '0;
  logic recValid, fmtErr, mismatchErr, waitDone, ovfFlag;
  logic [1:0] recKind;
  logic [DW-1:0] recTag, recData;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sigdec_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .NREG(NREG)) u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .sigAddr(SIG), .chkArm(chkArm), .chkMode(chkMode),
    .chkTarget(chkTarget), .recValid(recValid), .recReady(recReady),
    .recKind(recKind), .recTag(recTag), .recData(recData), .fmtErr(fmtErr),
    .mismatchErr(mismatchErr), .waitDone(waitDone), .ovfFlag(ovfFlag));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(logic [AW-1:0] a, logic [DW-1:0] d, logic we);
    busReq = 1; busWe = we; busAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 0; busWe = 0;
  endtask

  task automatic sig(logic [DW-1:0] d);
    beat(SIG, d, 1'b1);
  endtask

  task automatic flags(string req, logic f, logic m, logic w);
    check({req, " fmtErr"}, fmtErr, f);
    check({req, " mismatchErr"}, mismatchErr, m);
    check({req, " waitDone"}, waitDone, w);
  endtask

  task automatic pop(string req, logic [1:0] k, logic [DW-1:0] t, logic [DW-1:0] d);
    check({req, " recValid"}, recValid, 1'b1);
    check({req, " recKind"}, recKind, k);
    check({req, " recTag"}, recTag, t);
    check({req, " recData"}, recData, d);
    recReady = 1;
    @(negedge clk);
    recReady = 0;
  endtask

  task automatic arm(logic [1:0] m, logic [DW-9:0] t);
    chkArm = 1; chkMode = m; chkTarget = t;
    @(negedge clk);
    chkArm = 0;
  endtask

  task automatic t_reset();
    check("R9 reset recValid", recValid, 0);
    flags("R6 reset", 0, 0, 0);
    check("R10 reset ovfFlag", ovfFlag, 0);
  endtask

  task automatic t_ignore();
    beat(SIG, 32'h0000_0000, 1'b0);
    flags("R1 read", 0, 0, 0);
    check("R1 read no record", recValid, 0);
    beat(SIG + 4, 32'h0000_0507, 1'b1);
    flags("R1 other addr", 0, 0, 0);
    check("R1 other addr no record", recValid, 0);
  endtask

  task automatic t_init();
    sig(32'h0000_0000);
    flags("R6 first status", 0, 0, 1);
    pop("R2 R6 status record", 2'd0, 0, 0);
  endtask

  task automatic t_result();
    sig(32'h1234_5601);
    pop("R2 verdict", 2'd1, 0, 32'h0012_3456);
  endtask

  task automatic t_fmt();
    sig(32'hABCD_0007);
    flags("R5 unknown type", 1, 0, 0);
    check("R5 no record", recValid, 0);
  endtask

  task automatic t_csr();
    sig(32'h0000_3003);
    check("R4 head no record", recValid, 0);
    beat(SIG + 8, 32'h1111_1111, 1'b1);
    check("R4 foreign skipped", recValid, 0);
    sig(32'hDEAD_BEEF);
    pop("R4 csr pair", 2'd3, 32'h30, 32'hDEAD_BEEF);
  endtask

  task automatic t_dump();
    sig(32'h0000_0002);
    check("R3 head no record", recValid, 0);
    for (int i = 0; i < NREG; i++) begin
      logic [DW-1:0] v;
      v = (i == 5) ? 32'h0000_0007 : (32'h0101_0101 * i) ^ 32'h5A00_0000;
      if (i % 3 == 0) beat(SIG + 12, 32'h0000_0001, 1'b1);
      sig(v);
      check("R3 continuation no fmtErr", fmtErr, 0);
      pop("R3 dump entry", 2'd2, i, v);
    end
    sig(32'h0000_7701);
    pop("R3 back to head decode", 2'd1, 0, 32'h77);
  endtask

  task automatic t_next();
    arm(2'd1, 24'd5);
    sig(32'h0000_0400);
    flags("R7 mismatch", 0, 1, 0);
    pop("R7 status kept", 2'd0, 0, 4);
    sig(32'h0000_0500);
    flags("R7 disarmed", 0, 0, 0);
    pop("R7 later status", 2'd0, 0, 5);
  endtask

  task automatic t_wait();
    arm(2'd2, 24'd1);
    sig(32'h0000_0000);
    flags("R8 discard", 0, 0, 0);
    check("R8 discarded no record", recValid, 0);
    sig(32'h0000_0200);
    check("R8 discarded no record 2", recValid, 0);
    sig(32'h0000_0100);
    flags("R8 match", 0, 0, 1);
    pop("R8 match record", 2'd0, 0, 1);
    sig(32'h0000_0300);
    flags("R8 after match", 0, 0, 0);
    pop("R8 after match record", 2'd0, 0, 3);
  endtask

  task automatic t_off();
    arm(2'd1, 24'd9);
    arm(2'd0, 24'd9);
    sig(32'h0000_0700);
    flags("R11 off", 0, 0, 0);
    pop("R11 record", 2'd0, 0, 7);
  endtask

  task automatic t_ovf();
    for (int i = 0; i < DEPTH + 1; i++) sig(32'h0000_1001 + (i << 8));
    check("R10 ovfFlag", ovfFlag, 1);
    @(negedge clk);
    check("R9 held while not ready", recData, 32'h10);
    for (int i = 0; i < DEPTH; i++) pop("R9 order", 2'd1, 0, 32'h10 + i);
    check("R10 dropped record absent", recValid, 0);
    check("R10 sticky", ovfFlag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_init();
    t_result();
    t_fmt();
    t_csr();
    t_dump();
    t_next();
    t_wait();
    t_off();
    t_ovf();
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule